// File: doc/BRIEF.md
# Flow-Controlled Test Sequence Generator

This block emits a test data stream for exercising a data path. Each emitted word is either an incrementing counter value or the next state of a maximal-length linear feedback shift register. The stream starts from a value that software writes, and it moves only when the downstream sink signals ready, so back-pressure never drops or skips a word. The sequence word is `SEQ_W` bits wide and is tiled across the `DATA_W`-bit output field. A matching checker can therefore compare the upper copies against the lowest one and catch faults on every data line.

Software controls the block through two 32-bit registers on a simple bus. A write or read strobe is qualified by a one-bit address, and read data returns one cycle after the strobe. Word 0 holds the enable and the pattern select. Word 1 holds the start value.

A three-state machine sequences the generator. In `ST_OFF` it keeps reloading the start value with valid held low. `ST_OFF -> ST_RUN` is taken when enable is set. In `ST_RUN` it emits one word per edge at which ready is high. `ST_RUN -> ST_OFF` is taken when enable is cleared. `ST_RUN -> ST_RELOAD` is taken when the select bit no longer matches the mode latched at load time. `ST_RELOAD` reloads the start value in the new mode and then returns to `ST_RUN`, or goes to `ST_OFF` if enable has been cleared.

Top module: `test_seq_gen`

## Requirements
- R1: After reset `src_valid` is low and both register words read as zero.
- R2: Register word 0 (`reg_addr`=0) stores enable in bit 0 and pattern select in bit 1 (1 = counter, 0 = shift register). Word 1 stores the 32-bit start value. Both words read back exactly as written, all 32 bits. `reg_rdval` and `reg_rdata` are valid in the cycle after `reg_rd`, and `reg_rdval` is low otherwise.
- R3: A word is emitted (`src_valid` high for that cycle) only at a clock edge where `snk_ready` is high. While `snk_ready` is low the sequence holds its position.
- R4: Output bit i of `src_data` equals sequence bit (i mod `SEQ_W`), so full copies are repeated and the partial copy at the top is truncated.
- R5: The sequence start value is the low `SEQ_W` bits of word 1. Upper start bits are ignored.
- R6: While disabled, `src_valid` stays low whatever `snk_ready` does. The first word after enabling equals the start value.
- R7: In counter mode each emitted word is the previous word plus one, wrapping modulo 2^`SEQ_W`.
- R8: In shift-register mode the next word is {s[`SEQ_W`-2:0], XOR of s under a width-dependent maximal-length tap mask}. For `SEQ_W`=12 the mask is 12'h829. An all-zero word steps to 1, so a zero start value does not lock the sequence.
- R9: Changing the select bit while enabled restarts the sequence from the start value in the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | Register word select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after the strobe |
| reg_rdval | output | 1 | Read data valid |
| snk_ready | input | 1 | Downstream ready |
| src_data | output | DATA_W | Tiled sequence word |
| src_valid | output | 1 | Word valid strobe |

## Verification
The bench builds the block with `SEQ_W`=12 and `DATA_W`=40. That gives three full copies and a four-bit truncated copy, so the partial-copy rule is exercised. A 12-bit counter wraps within a short run from a start value of 12'hFFE. The 12-bit width also lets the upper start-value bits be written nonzero to show that they are ignored. The shift-register mode is checked from a zero start value, and a mode switch while running is checked against a restart from the start value. Random ready gaps are applied throughout.

// File: rtl/tsg_pkg.sv
package tsg_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_RUN    = 2'd1,
        ST_RELOAD = 2'd2
    } tsg_state_e;

    localparam int REG_W        = 32;
    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_SEL_BIT = 1;

    // single tap position t (1-based) as a mask bit
    function automatic logic [31:0] tap(input int t);
        return 32'h1 << (t - 1);
    endfunction

    // maximal-length feedback taps per sequence width
    function automatic logic [31:0] tsg_tap_mask(input int width);
        logic [31:0] m;
        case (width)
            3:  m = tap(3)  | tap(2);
            4:  m = tap(4)  | tap(3);
            5:  m = tap(5)  | tap(3);
            6:  m = tap(6)  | tap(5);
            7:  m = tap(7)  | tap(6);
            8:  m = tap(8)  | tap(6)  | tap(5) | tap(4);
            9:  m = tap(9)  | tap(5);
            10: m = tap(10) | tap(7);
            11: m = tap(11) | tap(9);
            12: m = tap(12) | tap(6)  | tap(4) | tap(1);
            13: m = tap(13) | tap(4)  | tap(3) | tap(1);
            14: m = tap(14) | tap(5)  | tap(3) | tap(1);
            15: m = tap(15) | tap(14);
            16: m = tap(16) | tap(15) | tap(13) | tap(4);
            17: m = tap(17) | tap(14);
            18: m = tap(18) | tap(11);
            19: m = tap(19) | tap(6)  | tap(2) | tap(1);
            20: m = tap(20) | tap(17);
            21: m = tap(21) | tap(19);
            22: m = tap(22) | tap(21);
            23: m = tap(23) | tap(18);
            24: m = tap(24) | tap(23) | tap(22) | tap(17);
            25: m = tap(25) | tap(22);
            26: m = tap(26) | tap(6)  | tap(2) | tap(1);
            27: m = tap(27) | tap(5)  | tap(2) | tap(1);
            28: m = tap(28) | tap(25);
            29: m = tap(29) | tap(27);
            30: m = tap(30) | tap(6)  | tap(4) | tap(1);
            31: m = tap(31) | tap(28);
            32: m = tap(32) | tap(22) | tap(2) | tap(1);
            default: m = tap(2) | tap(1);
        endcase
        return m;
    endfunction

endpackage

// File: rtl/tsg_ctrl_regs.sv
module tsg_ctrl_regs
    import tsg_pkg::*;
#(
    parameter int SEQ_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic             reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             reg_rdval,
    output logic             cfg_enable,
    output logic             cfg_sel_cntr,
    output logic [SEQ_W-1:0] cfg_start
);

    logic [REG_W-1:0] ctrl_word_q;
    logic [REG_W-1:0] start_word_q;

    // write side: full words stored so readback is exact
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_word_q  <= '0;
            start_word_q <= '0;
        end else if (reg_wr) begin
            if (reg_addr) start_word_q <= reg_wdata;
            else          ctrl_word_q  <= reg_wdata;
        end
    end

    // read side: one cycle latency
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata <= '0;
            reg_rdval <= 1'b0;
        end else begin
            reg_rdval <= reg_rd;
            if (reg_rd) reg_rdata <= reg_addr ? start_word_q : ctrl_word_q;
        end
    end

    assign cfg_enable   = ctrl_word_q[CTRL_EN_BIT];
    assign cfg_sel_cntr = ctrl_word_q[CTRL_SEL_BIT];
    assign cfg_start    = start_word_q[SEQ_W-1:0];

    p_rdval_after_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rdval);
    p_rdval_only_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> !reg_rdval);

endmodule

// File: rtl/tsg_seq_engine.sv
module tsg_seq_engine
    import tsg_pkg::*;
#(
    parameter int SEQ_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             sel_cntr,
    input  logic [SEQ_W-1:0] start_val,
    input  logic             snk_ready,
    output logic [SEQ_W-1:0] out_word,
    output logic             out_valid
);

    localparam logic [SEQ_W-1:0] TAPS = SEQ_W'(tsg_tap_mask(SEQ_W));
    localparam logic [SEQ_W-1:0] ONE  = SEQ_W'(1);

    tsg_state_e       state_q, state_d;
    logic [SEQ_W-1:0] seq_q;
    logic [SEQ_W-1:0] seq_next;
    logic             mode_q;      // 1 = counter, latched at load
    logic             mode_ok;
    logic             step;

    assign mode_ok = (sel_cntr == mode_q);
    assign step    = (state_q == ST_RUN) && enable && mode_ok && snk_ready;

    // next sequence value for the latched mode
    always_comb begin
        if (mode_q) begin
            seq_next = seq_q + ONE;
        end else if (seq_q == '0) begin
            seq_next = ONE;
        end else begin
            seq_next = {seq_q[SEQ_W-2:0], ^(seq_q & TAPS)};
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (enable) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!enable)      state_d = ST_OFF;
                else if (!mode_ok) state_d = ST_RELOAD;
            end
            ST_RELOAD: begin
                if (!enable) state_d = ST_OFF;
                else         state_d = ST_RUN;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // sequence and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q     <= '0;
            mode_q    <= 1'b0;
            out_word  <= '0;
            out_valid <= 1'b0;
        end else begin
            unique case (state_q)
                ST_OFF, ST_RELOAD: begin
                    seq_q     <= start_val;
                    mode_q    <= sel_cntr;
                    out_valid <= 1'b0;
                end
                ST_RUN: begin
                    out_valid <= step;
                    if (step) begin
                        out_word <= seq_q;
                        seq_q    <= seq_next;
                    end
                end
                default: out_valid <= 1'b0;
            endcase
        end
    end

    p_emit_needs_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(snk_ready));
    p_stall_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !snk_ready) |=> $stable(seq_q));
    p_off_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF) |=> !out_valid);
    p_lfsr_not_stuck_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !mode_q) |=> (seq_q != '0));
    p_reload_brief_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RELOAD) |=> (state_q != ST_RELOAD));

endmodule

// File: rtl/tsg_tiler.sv
module tsg_tiler #(
    parameter int SEQ_W  = 32,
    parameter int DATA_W = 40
) (
    input  logic [SEQ_W-1:0]  seq_word,
    output logic [DATA_W-1:0] tiled
);

    localparam int N_FULL = DATA_W / SEQ_W;
    localparam int N_REM  = DATA_W % SEQ_W;

    for (genvar c = 0; c < N_FULL; c++) begin : g_copy
        assign tiled[c*SEQ_W +: SEQ_W] = seq_word;
    end

    if (N_REM > 0) begin : g_partial
        assign tiled[DATA_W-1 -: N_REM] = seq_word[N_REM-1:0];
    end

endmodule

// File: rtl/test_seq_gen.sv
module test_seq_gen
    import tsg_pkg::*;
#(
    parameter int SEQ_W  = 32,
    parameter int DATA_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic              reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              reg_rdval,
    input  logic              snk_ready,
    output logic [DATA_W-1:0] src_data,
    output logic              src_valid
);

    logic             cfg_enable;
    logic             cfg_sel_cntr;
    logic [SEQ_W-1:0] cfg_start;
    logic [SEQ_W-1:0] word;

    tsg_ctrl_regs #(.SEQ_W(SEQ_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_rd       (reg_rd),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .reg_rdval    (reg_rdval),
        .cfg_enable   (cfg_enable),
        .cfg_sel_cntr (cfg_sel_cntr),
        .cfg_start    (cfg_start)
    );

    tsg_seq_engine #(.SEQ_W(SEQ_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (cfg_enable),
        .sel_cntr  (cfg_sel_cntr),
        .start_val (cfg_start),
        .snk_ready (snk_ready),
        .out_word  (word),
        .out_valid (src_valid)
    );

    tsg_tiler #(.SEQ_W(SEQ_W), .DATA_W(DATA_W)) u_tiler (
        .seq_word (word),
        .tiled    (src_data)
    );

    p_disabled_no_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!cfg_enable) && !cfg_enable) |-> !src_valid);

endmodule

// File: tb/test_seq_gen_tb.sv
module test_seq_gen_tb;

    localparam int SW = 12;
    localparam int DW = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic          reg_addr = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          reg_rdval;
    logic          snk_ready = 1'b0;
    logic [DW-1:0] src_data;
    logic          src_valid;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit force_ready = 1'b0;

    logic [SW-1:0] exp_q[$];
    string         tag_q[$];

    always #4 clk = ~clk;   // 125 MHz

    test_seq_gen #(.SEQ_W(SW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rdval(reg_rdval), .snk_ready(snk_ready), .src_data(src_data),
        .src_valid(src_valid)
    );

    function automatic logic [SW-1:0] m_next(logic [SW-1:0] s, bit cntr);
        if (cntr) return s + 1'b1;
        if (s == '0) return 1;
        return {s[SW-2:0], ^(s & 12'h829)};
    endfunction

    function automatic logic [DW-1:0] m_tile(logic [SW-1:0] s);
        logic [DW-1:0] d;
        for (int i = 0; i < DW; i++) d[i] = s[i % SW];
        return d;
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles == 100000) begin
            errors++; checks++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
            summary();
            $finish;
        end
    end

    // monitor: pops expected words, then drives ready for the next edge
    always @(negedge clk) begin
        if (rst_n && src_valid) begin
            checks++;
            if (!snk_ready) begin
                errors++;
                $display("FAIL R3: got valid with ready=0 expected no word");
            end
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R6: got word %h expected none", src_data);
            end else begin
                logic [SW-1:0] w;
                string t;
                w = exp_q.pop_front();
                t = tag_q.pop_front();
                if (src_data !== m_tile(w)) begin
                    errors++;
                    $display("FAIL %s/R4: got %h expected %h", t, src_data, m_tile(w));
                end
            end
        end
        snk_ready = ((exp_q.size() > 0) || force_ready) && ($urandom_range(0, 3) != 0);
    end

    task automatic push_seq(logic [SW-1:0] start, bit cntr, int n, string tag);
        logic [SW-1:0] s;
        s = start;
        for (int k = 0; k < n; k++) begin
            exp_q.push_back(s);
            tag_q.push_back((k == 0) ? "R6" : tag);
            s = m_next(s, cntr);
        end
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic reg_write(bit a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_check(bit a, logic [31:0] exp, string tag);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        checks++;
        if (reg_rdval !== 1'b1 || reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s: got rdval=%b data=%h expected rdval=1 data=%h",
                     tag, reg_rdval, reg_rdata, exp);
        end
        @(negedge clk);
        checks++;
        if (reg_rdval !== 1'b0) begin
            errors++;
            $display("FAIL R2: got rdval=%b expected 0 after strobe", reg_rdval);
        end
    endtask

    task automatic idle_ready(int n);
        force_ready = 1'b1;
        repeat (n) @(negedge clk);
        force_ready = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (src_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: got valid=%b expected 0", src_valid);
        end
        reg_check(1'b0, 32'h0, "R1");
        reg_check(1'b1, 32'h0, "R1");

        // start value with nonzero upper bits (R5), readback (R2)
        reg_write(1'b1, 32'hABCD_5FFE);
        reg_check(1'b1, 32'hABCD_5FFE, "R2");
        idle_ready(30);   // disabled: no word expected (R6)

        // counter from 12'hFFE, crosses the wrap (R7, R5)
        push_seq(12'hFFE, 1'b1, 20, "R7");
        reg_write(1'b0, 32'h3);
        drain();
        reg_check(1'b0, 32'h3, "R2");

        // switch to shift-register mode while enabled: restart (R9)
        reg_write(1'b0, 32'h1);
        push_seq(12'hFFE, 1'b0, 40, "R9");
        drain();

        // disable, zero start in shift-register mode (R8)
        reg_write(1'b0, 32'h0);
        reg_write(1'b1, 32'h0);
        idle_ready(10);
        push_seq(12'h000, 1'b0, 60, "R8");
        reg_write(1'b0, 32'h1);
        drain();

        // extra control bits read back; enable clear keeps valid low (R2, R6)
        reg_write(1'b0, 32'hF0F0_0002);
        reg_check(1'b0, 32'hF0F0_0002, "R2");
        idle_ready(20);

        // re-enable counter from a new start value (R6, R7)
        reg_write(1'b1, 32'h0000_0123);
        push_seq(12'h123, 1'b1, 25, "R7");
        reg_write(1'b0, 32'h3);
        drain();

        summary();
        $finish;
    end

endmodule